// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. It uses the same line settings as the transmitter that sends them: data length, parity on or off, parity sense and stick parity. It runs from a tick at sixteen times the baud rate, supplied from outside. A loopback select can replace the external line with the internal transmit path. A break sent by the local transmitter therefore reaches the receiver.

Each accepted character produces a one-cycle valid pulse. The byte, the parity-error flag, the framing-error flag and the break flag are all registered together with that pulse. All of them hold until the next character completes. Baud generation, buffering, interrupts and register access are handled elsewhere.

Top module: `serial_char_rx`

## Requirements
- R1: The data width follows `len_sel_i`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. The bits of `data_o` above the selected length read 0.
- R2: In the idle state, a tick that sees the line low, after the previous tick saw it high, begins a character. That tick is called T0. At tick T0+8 the line is sampled again. If it is high, the start is dropped and no character is produced.
- R3: Each later bit is sampled on the tick 16 ticks after the previous sample. The stop bit is therefore sampled at tick T0+8+16*(N+P+1), where N is the data width and P is 1 when parity is on. `valid_o` is high for exactly the one clock that follows that tick.
- R4: With `par_en_i`=1 and `par_stick_i`=0, one parity bit follows the data. `par_err_o` is set when the count of ones over the data and parity bit is odd while `par_even_i`=1, or even while `par_even_i`=0. With `par_en_i`=0 no parity bit is expected and `par_err_o` is 0.
- R5: With `par_en_i`=1 and `par_stick_i`=1, the parity bit must equal the inverse of `par_even_i`. Any other value sets `par_err_o`.
- R6: Only the first stop bit is sampled. `frame_err_o` is 1 exactly when it reads 0. Line activity after that sample, such as a low second stop bit, produces no character unless it forms a valid start.
- R7: `brk_o` is 1 when the data bits, the parity bit (if enabled) and the stop bit were all 0.
- R8: With `loopback_i`=1 the receiver listens to `txd_loop_i` and ignores `rxd_i`. With `loopback_i`=0 it is the other way round.
- R9: After reset, `valid_o`, `data_o` and all flags are 0 and the receiver is idle, treating the line as high.
- R10: A line that stays low after a character starts nothing. A new character needs a tick that sees the line high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 16x baud |
| loopback_i | input | 1 | 1 selects the internal transmit path |
| rxd_i | input | 1 | External serial line |
| txd_loop_i | input | 1 | Internal transmit line for loopback |
| len_sel_i | input | 2 | Data length code |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 even, 0 odd parity sense |
| par_stick_i | input | 1 | Fixed-value parity |
| data_o | output | 8 | Received character |
| valid_o | output | 1 | One-cycle character-complete pulse |
| par_err_o | output | 1 | Parity error of the last character |
| frame_err_o | output | 1 | First stop bit was 0 |
| brk_o | output | 1 | Last character was an all-zero break |

## Verification
The assertions assume three things about the inputs. The line settings and the loopback select do not change while a character is in flight. The serial line is already synchronous to the clock. Tick pulses are at least two clocks apart. The stimulus changes the settings only between characters, after the line has idled high. It moves the line only at clock edges that carry no tick, and it spaces ticks two clocks apart. Frames vary the length, parity mode, stop level and line source. Short start glitches, a low second stop bit and a held break line test the start and restart rules.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_line_sel.sv
module srx_line_sel (
  input  logic loopback_i,
  input  logic rxd_i,
  input  logic txd_loop_i,
  output logic line_o
);
  always_comb line_o = loopback_i ? txd_loop_i : rxd_i;
endmodule

// File: rtl/srx_tick_timer.sv
module srx_tick_timer #(
  parameter int OSR = 16,
  localparam int CW = $clog2(OSR)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic mid_o,
  output logic full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= clr_i ? '0 : cnt_q + CW'(1);
  end

  assign mid_o  = tick_i && (cnt_q == CW'(OSR/2 - 1));
  assign full_o = tick_i && (cnt_q == CW'(OSR - 1));
endmodule

// File: rtl/srx_parity_chk.sv
module srx_parity_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              err_o
);
  // unused upper data bits are already zero, so a full reduction is safe
  always_comb begin
    if (stick_i) err_o = (par_bit_i == even_i);
    else         err_o = (^data_i) ^ par_bit_i ^ ~even_i;
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import srx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  localparam int DATA_W  = MIN_BITS + (1 << LEN_W) - 1,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              loopback_i,
  input  logic              rxd_i,
  input  logic              txd_loop_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_stick_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frame_err_o,
  output logic              brk_o
);
  rx_state_e         state_q;
  logic              line, prev_line_q, mid, full, tmr_clr, par_bad;
  logic              par_bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q, last_idx;

  srx_line_sel u_sel (
    .loopback_i(loopback_i), .rxd_i(rxd_i), .txd_loop_i(txd_loop_i), .line_o(line)
  );

  assign tmr_clr = (state_q == RX_IDLE) || (state_q == RX_START && mid) || full;

  srx_tick_timer #(.OSR(OSR)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(tmr_clr),
    .mid_o(mid), .full_o(full)
  );

  srx_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data_i(shreg_q), .par_bit_i(par_bit_q), .even_i(par_even_i),
    .stick_i(par_stick_i), .err_o(par_bad)
  );

  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      prev_line_q <= 1'b1;
      shreg_q     <= '0;
      idx_q       <= '0;
      par_bit_q   <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      brk_o       <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        prev_line_q <= line;
        unique case (state_q)
          RX_IDLE: if (prev_line_q && !line) state_q <= RX_START;
          RX_START: if (mid) begin
            if (line) state_q <= RX_IDLE;
            else begin
              state_q   <= RX_DATA;
              idx_q     <= '0;
              shreg_q   <= '0;
              par_bit_q <= 1'b0;
            end
          end
          RX_DATA: if (full) begin
            shreg_q[idx_q] <= line;
            if (idx_q == last_idx) state_q <= par_en_i ? RX_PAR : RX_STOP;
            else                   idx_q   <= idx_q + IDX_W'(1);
          end
          RX_PAR: if (full) begin
            par_bit_q <= line;
            state_q   <= RX_STOP;
          end
          RX_STOP: if (full) begin
            data_o      <= shreg_q;
            valid_o     <= 1'b1;
            frame_err_o <= !line;
            par_err_o   <= par_en_i && par_bad;
            brk_o       <= !line && (shreg_q == '0) && !(par_en_i && par_bit_q);
            state_q     <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R3
  valid_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(tick_i));
  // R2
  start_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && mid && line) |=> (state_q == RX_IDLE && !valid_o));
  // R7
  brk_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && brk_o) |-> (frame_err_o && data_o == '0));
  // R1
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> (MIN_BITS + int'(len_sel_i))) == '0));
  // R4
  no_par_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !par_err_o);
  // R10
  no_low_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && tick_i && !prev_line_q) |=> state_q == RX_IDLE);
endmodule

// File: tb/serial_char_rx_bench.sv
module serial_char_rx_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b0, lb = 1'b0, rxd = 1'b1, txl = 1'b1;
  logic [1:0] len = 2'd3;
  logic       pen = 1'b0, peven = 1'b0, pstick = 1'b0;
  logic [7:0] data;
  logic       valid, perr, ferr, brk;

  typedef struct {
    int t;
    logic [7:0] d;
    logic pe, fe, bk;
    string tag;
  } exp_t;
  exp_t exq[$];

  int compared = 0, mismatched = 0;
  int drv_t = 0, tick_cnt = 0, last_idx = -1;
  bit fired = 0, done = 0, run = 0;

  always #10 clk = ~clk;

  serial_char_rx u_serial_char_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .loopback_i(lb), .rxd_i(rxd),
    .txd_loop_i(txl), .len_sel_i(len), .par_en_i(pen), .par_even_i(peven),
    .par_stick_i(pstick), .data_o(data), .valid_o(valid), .par_err_o(perr),
    .frame_err_o(ferr), .brk_o(brk)
  );

  always @(posedge clk) begin
    fired = 0;
    if (rst_n && tick) begin
      last_idx = tick_cnt;
      tick_cnt = tick_cnt + 1;
      fired = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at tick %0d", req, what, act, expv, last_idx);
    end
  endtask

  // reference: every clock the expected valid is decided by tick index alone
  always @(negedge clk) begin
    if (run) begin
      bit ev;
      ev = fired && exq.size() > 0 && exq[0].t == last_idx;
      chk(valid == ev, "R3", "valid_o", valid, ev);
      if (ev) begin
        chk(data == exq[0].d, exq[0].tag, "data_o", data, exq[0].d);
        chk(perr == exq[0].pe, exq[0].tag, "par_err_o", perr, exq[0].pe);
        chk(ferr == exq[0].fe, "R6", "frame_err_o", ferr, exq[0].fe);
        chk(brk == exq[0].bk, "R7", "brk_o", brk, exq[0].bk);
        void'(exq.pop_front());
      end
    end
  end

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    drv_t++;
  endtask

  task automatic put(input logic v, input bit use_lb, input int n);
    if (use_lb) begin txl = v; rxd = ~v; end
    else        begin rxd = v; txl = ~v; end
    repeat (n) do_tick();
  endtask

  // pb_mode: 0 correct parity, 1 inverted, 2 forced 0
  task automatic send(input logic [7:0] d, input logic [1:0] ln, input bit pe,
                      input bit ev, input bit st, input int pb_mode, input logic stop,
                      input bit use_lb, input logic tail_v, input int tail_n,
                      input string tag);
    int n;
    logic [7:0] dm;
    logic pb;
    exp_t e;
    @(negedge clk);
    len = ln; pen = pe; peven = ev; pstick = st; lb = use_lb;
    put(1'b1, use_lb, 3);
    n  = 5 + ln;
    dm = d & 8'((1 << n) - 1);
    pb = st ? ~ev : ((^dm) ^ ~ev);
    if (pb_mode == 1) pb = ~pb;
    if (pb_mode == 2) pb = 1'b0;
    e.t   = drv_t + 8 + 16 * (n + (pe ? 1 : 0) + 1);
    e.d   = dm;
    e.pe  = pe && (st ? (pb ^ ~ev) : ((^dm) ^ pb ^ ~ev));
    e.fe  = !stop;
    e.bk  = !stop && dm == 8'h0 && !(pe && pb);
    e.tag = tag;
    exq.push_back(e);
    put(1'b0, use_lb, 16);
    for (int i = 0; i < n; i++) put(dm[i], use_lb, 16);
    if (pe) put(pb, use_lb, 16);
    put(stop, use_lb, 16);
    if (tail_n > 0) put(tail_v, use_lb, tail_n);
    put(1'b1, use_lb, 4);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(valid == 0 && data == 0 && perr == 0 && ferr == 0 && brk == 0, "R9",
        "reset outputs", {valid, perr, ferr, brk, data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1;
    put(1'b1, 0, 4);
    // R1 lengths, R4 parity off
    send(8'hA5, 2'd3, 0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R1");
    send(8'hFF, 2'd0, 0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R1");
    send(8'h6B, 2'd1, 0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R1");
    send(8'hD3, 2'd2, 0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R1");
    // R4 even/odd, good and bad parity
    send(8'h37, 2'd3, 1, 1, 0, 0, 1'b1, 0, 1'b1, 0, "R4");
    send(8'h37, 2'd3, 1, 1, 0, 1, 1'b1, 0, 1'b1, 0, "R4");
    send(8'h1C, 2'd0, 1, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R4");
    send(8'h1C, 2'd2, 1, 0, 0, 1, 1'b1, 0, 1'b1, 0, "R4");
    // R5 stick parity
    send(8'h5A, 2'd3, 1, 1, 1, 0, 1'b1, 0, 1'b1, 0, "R5");
    send(8'h5A, 2'd3, 1, 1, 1, 1, 1'b1, 0, 1'b1, 0, "R5");
    send(8'h0F, 2'd1, 1, 0, 1, 0, 1'b1, 0, 1'b1, 0, "R5");
    send(8'h0F, 2'd1, 1, 0, 1, 1, 1'b1, 0, 1'b1, 0, "R5");
    // R6 framing error, and low second stop bit ignored
    send(8'h81, 2'd3, 0, 0, 0, 0, 1'b0, 0, 1'b1, 0, "R6");
    send(8'h42, 2'd3, 1, 1, 0, 0, 1'b1, 0, 1'b0, 6, "R6");
    // R2 short start glitches produce nothing
    put(1'b0, 0, 5); put(1'b1, 0, 20);
    put(1'b0, 0, 8); put(1'b1, 0, 20);
    send(8'h99, 2'd3, 0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R2");
    // R8 loopback path with rxd_i toggled opposite
    send(8'hC6, 2'd3, 1, 0, 0, 0, 1'b1, 1, 1'b1, 0, "R8");
    // R7 looped-back break held low, R10 no restart while low
    send(8'h00, 2'd3, 1, 1, 0, 2, 1'b0, 1, 1'b0, 60, "R7");
    send(8'h00, 2'd0, 0, 0, 0, 0, 1'b0, 0, 1'b0, 40, "R10");
    send(8'h00, 2'd3, 1, 0, 0, 2, 1'b0, 1, 1'b0, 10, "R7");
    send(8'h3C, 2'd3, 0, 0, 0, 0, 1'b1, 0, 1'b1, 0, "R10");
    put(1'b1, 0, 20);
    chk(exq.size() == 0, "R3", "characters outstanding", exq.size(), 0);
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R3 watchdog: actual hung expected done");
      report();
    end
  end
endmodule